// File: doc/BRIEF.md
# Segmented Operand Word Store

This block keeps the working set of a wide modular-arithmetic engine: four working operands and one modulus, each stored as 48 words of 32 bits (1536 bits in all). A host reaches any single word through a 9-bit word address. The arithmetic core sees every operand at full width at the same moment. It reads two operands through two selectors and the modulus on a port of its own, and it can replace one working operand in a single cycle.

A 2-bit precision select decides which words of every operand take part. In full mode all 48 words are used. In low mode only the bottom 16 words are used. In high mode the top 32 words are used. Words outside the chosen segment read as zero on both ports, and host writes to them are dropped. If the host addresses the operand that the core is replacing in the same cycle, the block raises a collision flag and the core write wins.

Top module: `seg_opmem`

## Requirements
- R1: The host address is split into a selector in bits 8:6 and a word index in bits 5:0. Selectors 0 to 3 pick working operands 0 to 3, and selector 4 picks the modulus. For selectors 5 to 7, host writes are dropped and host reads return zero.
- R2: Word index 0 holds bits 31:0 of an operand. Word k sits at bits 32k+31:32k on the core ports.
- R3: With precision 2'b11, all 48 words (indices 0 to 47) are active. Word indices 48 to 63 are never active.
- R4: With precision 2'b01, only words 0 to 15 are active. Other words read as zero on the host and core ports, and host writes to them are dropped.
- R5: With precision 2'b10, only words 16 to 47 are active. Words 0 to 15 read as zero and cannot be written by the host.
- R6: With precision 2'b00, no word is active. Every core output and every host read is zero.
- R7: Host read data appears two rising edges after the address is presented. After one edge, the output still holds the earlier result.
- R8: The collision output is high in any cycle where core write enable is set and the host selector equals the core destination operand. In that cycle the host write is dropped and the core data is stored.
- R9: A core write replaces the active words of the destination operand (selected by a 2-bit code, 0 to 3) in one edge. It leaves the inactive words and the other operands unchanged.
- R10: Reset (active-low) clears every stored word and the host read pipeline to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| prec_sel | input | 2 | Precision segment select |
| host_addr | input | 9 | Host word address (selector, index) |
| host_we | input | 1 | Host write enable |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, two-cycle latency |
| collision | output | 1 | Host addresses the operand the core is writing |
| x_sel | input | 2 | First core read operand |
| y_sel | input | 2 | Second core read operand |
| x_data | output | 1536 | First core read operand, masked to active words |
| y_data | output | 1536 | Second core read operand, masked to active words |
| mod_data | output | 1536 | Modulus, masked to active words |
| core_we | input | 1 | Core full-width write enable |
| dest_sel | input | 2 | Core write destination operand |
| core_wdata | input | 1536 | Core full-width write data |

## Verification
The assertions check, on every cycle, the following properties:
- The masking of the core outputs in the low, high and idle modes.
- That collision only rises together with a core write.
- That host reads of an inactive or unmapped address return zero two cycles later.

Some behaviour depends on the stored contents, so only the bench scenarios can show it:
- Which word lands at which bit position.
- That dropped host writes really leave memory unchanged.
- That the core write wins a collision.
- That a core write in high mode spares the low words.

The bench shows these by sweeping every operand and word against an arithmetic pattern.

// File: rtl/seg_opmem.sv
module seg_opmem #(
  parameter int WORD_W   = 32,
  parameter int WORDS    = 48,
  parameter int LO_WORDS = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                prec_sel,
  input  logic [8:0]                host_addr,
  input  logic                      host_we,
  input  logic [WORD_W-1:0]         host_wdata,
  output logic [WORD_W-1:0]         host_rdata,
  output logic                      collision,
  input  logic [1:0]                x_sel,
  input  logic [1:0]                y_sel,
  output logic [WORD_W*WORDS-1:0]   x_data,
  output logic [WORD_W*WORDS-1:0]   y_data,
  output logic [WORD_W*WORDS-1:0]   mod_data,
  input  logic                      core_we,
  input  logic [1:0]                dest_sel,
  input  logic [WORD_W*WORDS-1:0]   core_wdata
);
  localparam int OPS    = 5;
  localparam int IDX_W  = 6;
  localparam int FULL_W = WORD_W * WORDS;
  localparam int LO_W   = WORD_W * LO_WORDS;

  logic [WORD_W-1:0] mem [OPS][WORDS];
  logic [WORD_W-1:0] rd_q;
  logic [1:0]        age;

  function automatic logic active(input logic [IDX_W-1:0] i, input logic [1:0] p);
    case (p)
      2'b11:   active = (i < IDX_W'(WORDS));
      2'b01:   active = (i < IDX_W'(LO_WORDS));
      2'b10:   active = (i >= IDX_W'(LO_WORDS)) && (i < IDX_W'(WORDS));
      default: active = 1'b0;
    endcase
  endfunction

  wire [2:0]       host_op  = host_addr[8:6];
  wire [IDX_W-1:0] host_idx = host_addr[5:0];
  wire             host_hit = (host_op < 3'(OPS)) && active(host_idx, prec_sel);

  assign collision = core_we && (host_op == {1'b0, dest_sel});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int o = 0; o < OPS; o++)
        for (int w = 0; w < WORDS; w++)
          mem[o][w] <= '0;
    end else begin
      if (host_we && host_hit && !collision)
        mem[host_op][host_idx] <= host_wdata;
      if (core_we)
        for (int w = 0; w < WORDS; w++)
          if (active(IDX_W'(w), prec_sel))
            mem[{1'b0, dest_sel}][w] <= core_wdata[w*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q       <= '0;
      host_rdata <= '0;
      age        <= '0;
    end else begin
      rd_q       <= host_hit ? mem[host_op][host_idx] : '0;
      host_rdata <= rd_q;
      if (age != 2'd3) age <= age + 2'd1;
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_core_rd
    wire on = active(IDX_W'(w), prec_sel);
    assign x_data[w*WORD_W +: WORD_W]   = on ? mem[{1'b0, x_sel}][w] : '0;
    assign y_data[w*WORD_W +: WORD_W]   = on ? mem[{1'b0, y_sel}][w] : '0;
    assign mod_data[w*WORD_W +: WORD_W] = on ? mem[OPS-1][w] : '0;
  end

  AST_COLL_NEEDS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    collision |-> core_we); // R8
  AST_LO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    prec_sel == 2'b01 |-> x_data[FULL_W-1:LO_W] == '0 && y_data[FULL_W-1:LO_W] == '0); // R4
  AST_HI_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    prec_sel == 2'b10 |-> x_data[LO_W-1:0] == '0 && mod_data[LO_W-1:0] == '0); // R5
  AST_IDLE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    prec_sel == 2'b00 |-> x_data == '0 && y_data == '0 && mod_data == '0); // R6
  AST_RD_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    age == 2'd3 && !$past(host_hit, 2) |-> host_rdata == '0); // R1
endmodule

// File: tb/seg_opmem_tb_top.sv
`timescale 1ns/1ps
module seg_opmem_tb_top;
  localparam int WW = 32, NW = 48, FW = WW * NW;

  logic clk = 0, rst_n = 0;
  logic [1:0] prec_sel = 2'b11, x_sel = 0, y_sel = 0, dest_sel = 0;
  logic [8:0] host_addr = 0;
  logic host_we = 0, core_we = 0;
  logic [WW-1:0] host_wdata = 0, host_rdata;
  logic collision;
  logic [FW-1:0] x_data, y_data, mod_data, core_wdata = '0;

  int errors = 0, checks = 0;
  logic [WW-1:0] model [5][NW];

  always #4 clk = ~clk;

  seg_opmem dut_i (.clk, .rst_n, .prec_sel, .host_addr, .host_we, .host_wdata,
    .host_rdata, .collision, .x_sel, .y_sel, .x_data, .y_data, .mod_data,
    .core_we, .dest_sel, .core_wdata);

  function automatic logic [WW-1:0] pat(int op, int w);
    return 32'h1000_0000 * (op + 1) + w * 32'h0001_0203 + 32'h55;
  endfunction

  function automatic bit act(int w, logic [1:0] p);
    case (p)
      2'b11: return w < 48;
      2'b01: return w < 16;
      2'b10: return w >= 16 && w < 48;
      default: return 0;
    endcase
  endfunction

  task automatic check(logic [WW-1:0] a, logic [WW-1:0] e, string req);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic hwr(int op, int w, logic [WW-1:0] d);
    host_addr = {3'(op), 6'(w)}; host_wdata = d; host_we = 1;
    tick(); host_we = 0;
  endtask

  task automatic hrd(int op, int w, output logic [WW-1:0] d);
    host_addr = {3'(op), 6'(w)};
    tick(); tick(); d = host_rdata;
  endtask

  task automatic core_cmp(string req);
    for (int o = 0; o < 4; o++) begin
      x_sel = 2'(o); y_sel = 2'(3 - o); #1;
      for (int w = 0; w < NW; w++) begin
        check(x_data[w*WW +: WW], act(w, prec_sel) ? model[o][w] : '0, req);
        check(y_data[w*WW +: WW], act(w, prec_sel) ? model[3-o][w] : '0, req);
        check(mod_data[w*WW +: WW], act(w, prec_sel) ? model[4][w] : '0, req);
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [WW-1:0] d;
    for (int o = 0; o < 5; o++) for (int w = 0; w < NW; w++) model[o][w] = '0;
    repeat (3) tick();
    check(host_rdata, '0, "R10 rdata");
    check(x_data[WW-1:0] | mod_data[FW-1 -: WW], '0, "R10 core");
    rst_n = 1; tick();

    // R1 R2 R3: full mode sweep of every operand and word
    for (int o = 0; o < 5; o++) for (int w = 0; w < NW; w++) begin
      hwr(o, w, pat(o, w)); model[o][w] = pat(o, w);
    end
    for (int o = 0; o < 5; o++) for (int w = 0; w < NW; w++) begin
      hrd(o, w, d); check(d, model[o][w], "R1 R3 host read");
    end
    core_cmp("R2 R3 core read");

    // R1: unmapped selectors and indices above 47
    for (int s = 5; s < 8; s++) begin
      hwr(s, 3, 32'hBAD0_0000 + s); hrd(s, 3, d); check(d, '0, "R1 unmapped sel");
    end
    hwr(0, 50, 32'hBAD1); hrd(0, 50, d); check(d, '0, "R3 index 50");
    core_cmp("R1 no side effect");

    // R7: latency
    hrd(7, 0, d);
    host_addr = {3'd2, 6'd5}; tick();
    check(host_rdata, '0, "R7 one edge");
    tick(); check(host_rdata, model[2][5], "R7 two edges");

    // R4: low mode
    prec_sel = 2'b01;
    core_cmp("R4 core mask");
    hrd(1, 20, d); check(d, '0, "R4 host read inactive");
    hrd(1, 10, d); check(d, model[1][10], "R4 host read active");
    hwr(1, 20, 32'h1111_2222); hwr(1, 10, 32'h3333_4444); model[1][10] = 32'h3333_4444;

    // R5: high mode
    prec_sel = 2'b10;
    core_cmp("R5 core mask");
    hrd(3, 5, d); check(d, '0, "R5 host read inactive");
    hrd(3, 40, d); check(d, model[3][40], "R5 host read active");
    hwr(3, 5, 32'h5555_6666);

    // R6: idle mode
    prec_sel = 2'b00;
    core_cmp("R6 all zero");
    hrd(4, 20, d); check(d, '0, "R6 host read");

    prec_sel = 2'b11;
    core_cmp("R4 R5 dropped writes");

    // R9: core write in high mode
    prec_sel = 2'b10;
    for (int w = 0; w < NW; w++) core_wdata[w*WW +: WW] = 32'hC0DE_0000 + w;
    dest_sel = 2; core_we = 1; host_addr = {3'd0, 6'd0}; tick(); core_we = 0;
    for (int w = 16; w < NW; w++) model[2][w] = 32'hC0DE_0000 + w;
    prec_sel = 2'b11;
    core_cmp("R9 core write");

    // R8: collision
    dest_sel = 1; core_we = 1; host_addr = {3'd1, 6'd30}; host_wdata = 32'hDEAD_BEEF; host_we = 1; #1;
    check(32'(collision), 1, "R8 collision high");
    tick(); core_we = 0; host_we = 0;
    for (int w = 0; w < NW; w++) model[1][w] = 32'hC0DE_0000 + w;
    hrd(1, 30, d); check(d, 32'hC0DE_001E, "R8 core wins");
    dest_sel = 1; core_we = 1; host_addr = {3'd2, 6'd7}; host_wdata = 32'h7777_0007; host_we = 1; #1;
    check(32'(collision), 0, "R8 other operand");
    tick(); core_we = 0; host_we = 0; model[2][7] = 32'h7777_0007;
    #1 check(32'(collision), 0, "R8 idle");
    core_cmp("R8 R9 final");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule